// File: doc/BRIEF.md
# Clock-Buffer Configuration Slave (Two-Wire, Block Transfers)

This block is the configuration port of a clock-distribution device. It listens on a two-wire serial bus: a clock line and a bidirectional, open-drain data line. It keeps a small bank of byte registers, and each bit of that bank enables one clock output. The bank resets to all ones, so every output is enabled and the device runs correctly even if no master ever touches the bus.

The block accepts only block transfers. A write carries the slave address with the direction bit, a command byte, a count byte and then data bytes. A read carries the slave address, after which the slave returns a count byte followed by the register bytes. In both cases the data bytes start at register 0 and ascend. The master can end either transfer after any whole byte.

Both bus lines are oversampled in the system clock domain. The data output is a pull-low request for an external open-drain pad.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: During and right after reset, `out_en_o` is all ones and `sda_low_o` is 0, because every register byte defaults to 8'hFF.
- R2: The slave answers only the 7-bit address `DEV_ADDR` (default 7'h69), sent MSB first with the direction bit (0 = write, 1 = read) last. On any other address it does not acknowledge, and bytes that follow until the next START have no effect.
- R3: A block write is: address byte with direction 0, a command byte (any value, not stored), a count byte (any value, not stored), then data bytes. The first data byte goes to register 0 and the next one to register 1. Every byte is MSB first.
- R4: The slave acknowledges every byte it accepts by pulling data low for the whole ninth clock of that byte.
- R5: If a write ends with STOP after any whole data byte, the bytes already completed keep their new values and the remaining registers keep their old values.
- R6: In a write, data bytes beyond the last register are not acknowledged and change nothing.
- R7: A block read returns first a count byte equal to the number of register bytes (2 by default), then register 0, register 1 and so on. Bytes requested past the last register read as 8'h00. All bytes are MSB first.
- R8: When the master does not acknowledge a read byte, or sends STOP, the slave releases the data line and drives nothing until the next START.
- R9: `out_en_o[i]` equals bit i mod 8 of register i/8. Register bits above output NOUT-1 are still stored and read back.
- R10: The slave starts pulling the data line low only while the bus clock is low.
- R11: A START at any point, including a repeated START in the middle of a transfer, returns the slave to the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_low_o | output | 1 | 1 asks the pad to pull the data line low; 0 releases it |
| out_en_o | output | NOUT | Per-output enable bits, 1 = output enabled |

## Verification
Errors in the byte phase or bit counter become visible at the ports within one byte. An acknowledge appears or goes missing on the ninth clock, or a read byte comes back shifted by one bit. An error in the register index shows up as a wrong `out_en_o` pattern within a few system clocks after STOP, or as bytes in the wrong order on the following block read. A slave that keeps driving after a NACK reads back as zero bits on the next byte the master clocks, so the fault shows within eight bus clocks.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } byte_kind_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_s,
  output logic stop_s
);
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;
  logic            scl_p;
  logic            sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_p    = scl_sh[STAGES];
  assign sda_p    = sda_sh[STAGES];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_s  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_s   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_cfg_bank.sv
module tw_cfg_bank #(
  parameter int NBYTES = 2,
  parameter int NOUT   = 10,
  parameter int IDXW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_data,
  output logic [NOUT-1:0] out_en
);
  logic [NBYTES*8-1:0] bank;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g*8 +: 8] <= 8'hFF;
      end else if (wr_en && wr_idx == IDXW'(g)) begin
        bank[g*8 +: 8] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_idx == IDXW'(i)) rd_data = bank[i*8 +: 8];
    end
  end

  assign out_en = bank[NOUT-1:0];
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NBYTES   = 2,
  parameter int         IDXW     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_s,
  input  logic            stop_s,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_low_o
);
  localparam logic [7:0] CNT_BYTE = 8'(NBYTES);

  bus_state_t      state;
  byte_kind_t      kind;
  byte_kind_t      next_kind;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [7:0]      rx_byte;
  logic            rw;
  logic            ack_pend;
  logic [IDXW-1:0] idx;
  logic            in_bank;
  logic            drv;

  assign rx_byte   = {shreg[6:0], sda_s};
  assign in_bank   = idx < IDXW'(NBYTES);
  assign rd_idx    = idx;
  assign sda_low_o = drv;

  always_comb begin
    unique case (kind)
      K_ADDR:  next_kind = K_CMD;
      K_CMD:   next_kind = K_CNT;
      default: next_kind = K_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      ack_pend <= 1'b0;
      idx      <= '0;
      drv      <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_s) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        idx    <= '0;
        drv    <= 1'b0;
      end else if (stop_s) begin
        state <= S_IDLE;
        drv   <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          S_RX: begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              unique case (kind)
                K_ADDR: begin
                  ack_pend <= (rx_byte[7:1] == DEV_ADDR);
                  rw       <= rx_byte[0];
                end
                K_DATA: begin
                  ack_pend <= in_bank;
                  if (in_bank) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= rx_byte;
                    idx     <= idx + 1'b1;
                  end
                end
                default: ack_pend <= 1'b1;
              endcase
            end
          end
          S_TX:    bitcnt <= bitcnt + 4'd1;
          S_MACK:  if (sda_s) state <= S_IDLE;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_RX: begin
            if (bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (ack_pend) begin
                state <= S_ACK;
                drv   <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ACK: begin
            bitcnt <= '0;
            if (kind == K_ADDR && rw) begin
              shreg <= CNT_BYTE;
              drv   <= !CNT_BYTE[7];
              idx   <= '0;
              state <= S_TX;
            end else begin
              drv   <= 1'b0;
              kind  <= next_kind;
              state <= S_RX;
            end
          end
          S_TX: begin
            if (bitcnt == 4'd8) begin
              drv   <= 1'b0;
              state <= S_MACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              drv   <= !shreg[6];
            end
          end
          S_MACK: begin
            shreg  <= rd_data;
            drv    <= !rd_data[7];
            bitcnt <= '0;
            state  <= S_TX;
            if (in_bank) idx <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NOUT        = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_low_o,
  output logic [NOUT-1:0] out_en_o
);
  localparam int NBYTES = (NOUT + 7) / 8;
  localparam int IDXW   = $clog2(NBYTES + 1);

  logic            scl_s;
  logic            sda_s;
  logic            scl_rise;
  logic            scl_fall;
  logic            start_s;
  logic            stop_s;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;
  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_data;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_s(start_s), .stop_s(stop_s)
  );

  tw_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NBYTES(NBYTES), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_s(start_s), .stop_s(stop_s), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_low_o(sda_low_o)
  );

  tw_cfg_bank #(.NBYTES(NBYTES), .NOUT(NOUT), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .out_en(out_en_o)
  );
endmodule

// File: rtl/clkbuf_cfg_slave_chk.sv
module clkbuf_cfg_slave_chk #(
  parameter int NOUT   = 10,
  parameter int NBYTES = 2,
  parameter int IDXW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            stop_s,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic            sda_low_o,
  input logic [NOUT-1:0] out_en_o
);
  logic past_rst;

  always_ff @(posedge clk) past_rst <= rst;

  // R1: defaults visible in the cycle after a reset cycle
  always @(posedge clk) begin
    if (past_rst) begin
      p_reset_defaults_r1 : assert (out_en_o == '1 && !sda_low_o)
        else $error("reset defaults violated");
    end
  end

  p_write_in_bank_r6 : assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IDXW'(NBYTES)));

  p_drive_scl_low_r10 : assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> !scl_s);

  p_release_on_stop_r8 : assert property (@(posedge clk) disable iff (rst)
    stop_s |=> !sda_low_o);

  p_en_change_on_write_r5 : assert property (@(posedge clk) disable iff (rst)
    !$stable(out_en_o) |-> $past(wr_en));
endmodule

bind clkbuf_cfg_slave clkbuf_cfg_slave_chk #(
  .NOUT(NOUT), .NBYTES(NBYTES), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_s(stop_s), .wr_en(wr_en),
  .wr_idx(wr_idx), .sda_low_o(sda_low_o), .out_en_o(out_en_o)
);

// File: tb/clkbuf_cfg_slave_test.sv
module clkbuf_cfg_slave_test;
  localparam int H = 8;
  localparam logic [7:0] AW = 8'hD2;
  localparam logic [7:0] AR = 8'hD3;
  // each entry: {byte0, byte1, expected out_en}
  localparam logic [25:0] VEC [4] = '{
    {8'h00, 8'h00, 10'h000},
    {8'hA5, 8'h02, 10'h2A5},
    {8'h3C, 8'hF1, 10'h13C},
    {8'hFF, 8'hFF, 10'h3FF}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_low;
  logic [9:0] out_en;
  wire        sda_line = !(m_low || sda_low);
  int         n_cmp = 0;
  int         n_bad = 0;
  int         viol = 0;
  logic       prev_drv = 1'b0;
  logic       done = 1'b0;
  logic       ack;
  logic [7:0] rb;

  always #2 clk = ~clk;

  clkbuf_cfg_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_low_o(sda_low), .out_en_o(out_en)
  );

  // R10 monitor: drive may only begin while the bus clock is low
  always @(posedge clk) begin
    prev_drv <= sda_low;
    if (sda_low && !prev_drv && scl) viol++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wt(H); scl = 1'b1; wt(H);
    m_low = 1'b1; wt(H); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(H); scl = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
    end
    m_low = 1'b0; wt(H); scl = 1'b1; wt(H / 2);
    a = !sda_line;
    wt(H / 2); scl = 1'b0; wt(2);
  endtask

  task automatic recv(input logic m_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(H / 2);
      b[i] = sda_line;
      wt(H / 2); scl = 1'b0; wt(2);
    end
    m_low = m_ack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2);
    m_low = 1'b0;
  endtask

  task automatic write_hdr(input string req);
    bus_start();
    send(AW, ack);   chk({req, " addr ack"}, 16'(ack), 16'd1);
    send(8'h00, ack); chk({req, " cmd ack"}, 16'(ack), 16'd1);
    send(8'h02, ack); chk({req, " count ack"}, 16'(ack), 16'd1);
  endtask

  initial begin
    wt(5);
    chk("R1 out_en in reset", 16'(out_en), 16'h03FF);
    rst = 1'b0;
    wt(3);
    chk("R1 out_en after reset", 16'(out_en), 16'h03FF);
    chk("R1 sda released", 16'(sda_low), 16'd0);

    // R3 / R9 / R4: table of block writes
    for (int v = 0; v < 4; v++) begin
      write_hdr("R4");
      send(VEC[v][25:18], ack); chk("R4 data0 ack", 16'(ack), 16'd1);
      send(VEC[v][17:10], ack); chk("R4 data1 ack", 16'(ack), 16'd1);
      bus_stop();
      chk("R3 R9 out_en after write", 16'(out_en), 16'(VEC[v][9:0]));
    end

    // R7: block read with count, registers, past end
    write_hdr("R3");
    send(8'h5A, ack); send(8'hC6, ack);
    bus_stop();
    chk("R9 mapping 5A/C6", 16'(out_en), 16'h025A);
    bus_start();
    send(AR, ack); chk("R7 read addr ack", 16'(ack), 16'd1);
    recv(1'b1, rb); chk("R7 count byte", 16'(rb), 16'h0002);
    recv(1'b1, rb); chk("R7 reg0", 16'(rb), 16'h005A);
    recv(1'b1, rb); chk("R7 reg1 full byte", 16'(rb), 16'h00C6);
    recv(1'b0, rb); chk("R7 past end", 16'(rb), 16'h0000);
    // R8: after NACK the slave must not drive
    recv(1'b0, rb); chk("R8 released after NACK", 16'(rb), 16'h00FF);
    bus_stop();
    chk("R8 idle after stop", 16'(sda_low), 16'd0);

    // R5: stop after first data byte
    write_hdr("R5");
    send(8'h11, ack);
    bus_stop();
    chk("R5 partial write", 16'(out_en), 16'h0211);

    // R6: byte past last register
    write_hdr("R6");
    send(8'h77, ack); send(8'h81, ack);
    send(8'h99, ack); chk("R6 extra byte nack", 16'(ack), 16'd0);
    bus_stop();
    chk("R6 regs unchanged by extra", 16'(out_en), 16'h0177);

    // R2: wrong address
    bus_start();
    send(8'hA0, ack); chk("R2 wrong addr nack", 16'(ack), 16'd0);
    send(8'h00, ack); send(8'h02, ack); send(8'h00, ack); send(8'h00, ack);
    bus_stop();
    chk("R2 out_en untouched", 16'(out_en), 16'h0177);

    // R11: repeated start mid-write becomes a read
    bus_start();
    send(AW, ack); send(8'h00, ack);
    bus_start();
    send(AR, ack); chk("R11 read addr ack after restart", 16'(ack), 16'd1);
    recv(1'b1, rb); chk("R11 count after restart", 16'(rb), 16'h0002);
    recv(1'b0, rb); chk("R11 reg0 after restart", 16'(rb), 16'h0077);
    bus_stop();

    chk("R10 drive began with clock low", 16'(viol), 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule